// File: doc/BRIEF.md
# Network Reconfiguration Image Loader

This block assembles a configuration image for a second programmable device out of numbered cells that arrive over a network path. Each cell opens with a header word that carries its sequence number and a final-cell flag, followed by a fixed number of payload words. The loader accepts cells strictly in order and writes each accepted payload into an external program memory at an address derived from the sequence number. It answers every cell with an acknowledgement. Out-of-order cells get a negative acknowledgement that names the number the loader still needs. Repeated cells are acknowledged again but never rewritten.

Once the final cell has been accepted, the image is marked complete. A separate start command then streams the stored words, one byte at a time, into the target device's configuration port. The port has a write strobe and a busy back-pressure input. In full mode the loader first pulses the device's active-low init line and waits for the device to signal ready. In partial mode it skips the init step and writes frames only, so logic already running in the target is left undisturbed. The cell input never stalls, and the loader keeps answering cells while it programs the device.

Top module: `cfg_image_loader`

## Requirements
- R1: A header beat is a `cell_valid` beat with `cell_sop` high. Header bits [5:0] carry the sequence number and bit 31 the final-cell flag. The next 11 `cell_valid` beats are payload words 0..10. Payload word k of an accepted cell `s` is written to memory address `s*11+k`.
- R2: A cell whose sequence number is above the next expected number causes no memory write. It is answered with `ack_nack`=1 and `ack_seq` equal to the expected number.
- R3: A cell whose sequence number is below the expected number, or any cell after the image is complete, causes no memory write. It is answered with `ack_nack`=0 and `ack_seq` equal to its own number.
- R4: `ack_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the last payload beat, and at no other time.
- R5: `img_complete` rises only after the acknowledgement of the accepted cell that carries the final flag, and then stays high. The image length is (final sequence number + 1) × 11 words.
- R6: A command sets `cmd_resp_valid` one cycle later. `cmd_resp_ok`=1 only when the image is complete and the loader is idle or finished; otherwise it is 0 and the port stays silent.
- R7: A full-mode start (`cmd_partial`=0) drives `dev_prog_n` low for exactly 4 cycles, then waits for `dev_ready` high before the first `cfg_we`.
- R8: A partial-mode start (`cmd_partial`=1) never drives `dev_prog_n` low and starts writing without waiting for `dev_ready`.
- R9: Image words are sent in address order, each most-significant byte first. `cfg_we` is high only while `cfg_busy` is low, and `cfg_byte` holds its value while a write is stalled.
- R10: After exactly image-length × 4 strobes, `prog_done` rises. It stays high until the next accepted start, which clears it.
- R11: Cells are processed and acknowledged while the device is being programmed.
- R12: `cell_valid` low beats inside a cell are ignored and do not advance the payload count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_valid | input | 1 | Cell beat valid |
| cell_sop | input | 1 | Beat is a cell header |
| cell_data | input | 32 | Header or payload word |
| ack_valid | output | 1 | Acknowledgement strobe |
| ack_nack | output | 1 | 1 = negative acknowledgement |
| ack_seq | output | 6 | Acknowledged or expected sequence number |
| mem_we | output | 1 | Program memory write enable |
| mem_waddr | output | 10 | Program memory write address |
| mem_wdata | output | 32 | Program memory write data |
| mem_re | output | 1 | Program memory read enable |
| mem_raddr | output | 10 | Program memory read address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |
| cmd_valid | input | 1 | Start command |
| cmd_partial | input | 1 | 1 = partial mode, 0 = full mode |
| cmd_resp_valid | output | 1 | Command response strobe |
| cmd_resp_ok | output | 1 | 1 = started, 0 = not ready |
| img_complete | output | 1 | Whole image received |
| dev_prog_n | output | 1 | Active-low device init pulse |
| dev_ready | input | 1 | Device ready after init |
| cfg_we | output | 1 | Configuration byte write strobe |
| cfg_byte | output | 8 | Configuration byte |
| cfg_busy | input | 1 | Configuration port busy |
| prog_done | output | 1 | Image fully written to device |

## Verification
The hardest situation to reach is a cell arriving while the configuration stream is running under back-pressure. It needs a complete image, an accepted start, a busy pattern that stalls writes, and a cell exchange, all at once. The bench reaches it by forking two scenario threads after the full-mode start. One toggles `cfg_busy` every third cycle and raises `dev_ready` late. The other sends a repeated cell and checks its acknowledgement. The captured byte stream is then compared word by word against the image.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [1:0] {CELL_ACC, CELL_DUP, CELL_NAK} cell_cls_e;
  typedef enum logic {RX_HDR, RX_PAY} rx_st_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_WAIT, ST_FETCH, ST_LATCH, ST_SEND, ST_DONE
  } strm_st_e;
endpackage

// File: rtl/cfg_cell_rx.sv
module cfg_cell_rx
  import cfg_ldr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WPC    = 11,
  parameter int SEQ_W  = 6,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  input  logic              cell_sop,
  input  logic [DATA_W-1:0] cell_data,
  output logic              ack_valid,
  output logic              ack_nack,
  output logic [SEQ_W-1:0]  ack_seq,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              img_complete,
  output logic [AW:0]       img_words
);
  localparam int IDX_W = (WPC > 1) ? $clog2(WPC) : 1;
  localparam int CNT_W = SEQ_W + 1;
  localparam logic [AW-1:0]    WPC_A   = AW'(WPC);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(WPC - 1);

  rx_st_e            rx_q, rx_d;
  cell_cls_e         cls_q, cls_d, hdr_cls;
  logic [SEQ_W-1:0]  seq_q, seq_d, hdr_seq;
  logic              last_q, last_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CNT_W-1:0]  expect_q, expect_d, total_q, total_d;
  logic              cmpl_q, cmpl_d;
  logic              ackv_q, ackv_d, nack_q, nack_d;
  logic [SEQ_W-1:0]  aseq_q, aseq_d;

  assign hdr_seq = cell_data[SEQ_W-1:0];

  always_comb begin
    if (cmpl_q || ({1'b0, hdr_seq} < expect_q)) hdr_cls = CELL_DUP;
    else if ({1'b0, hdr_seq} == expect_q)       hdr_cls = CELL_ACC;
    else                                        hdr_cls = CELL_NAK;
  end

  always_comb begin
    rx_d     = rx_q;
    cls_d    = cls_q;
    seq_d    = seq_q;
    last_d   = last_q;
    idx_d    = idx_q;
    addr_d   = addr_q;
    expect_d = expect_q;
    total_d  = total_q;
    cmpl_d   = cmpl_q;
    ackv_d   = 1'b0;
    nack_d   = nack_q;
    aseq_d   = aseq_q;
    case (rx_q)
      RX_HDR: begin
        if (cell_valid && cell_sop) begin
          rx_d   = RX_PAY;
          cls_d  = hdr_cls;
          seq_d  = hdr_seq;
          last_d = cell_data[DATA_W-1];
          idx_d  = '0;
          addr_d = AW'(hdr_seq) * WPC_A;
        end
      end
      default: begin
        if (cell_valid) begin
          if (idx_q == IDX_END) begin
            rx_d   = RX_HDR;
            ackv_d = 1'b1;
            nack_d = (cls_q == CELL_NAK);
            aseq_d = (cls_q == CELL_NAK) ? expect_q[SEQ_W-1:0] : seq_q;
            if (cls_q == CELL_ACC) begin
              expect_d = expect_q + 1'b1;
              if (last_q) begin
                cmpl_d  = 1'b1;
                total_d = expect_q + 1'b1;
              end
            end
          end else begin
            idx_d  = idx_q + 1'b1;
            addr_d = addr_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= RX_HDR;
      cls_q    <= CELL_DUP;
      seq_q    <= '0;
      last_q   <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      expect_q <= '0;
      total_q  <= '0;
      cmpl_q   <= 1'b0;
      ackv_q   <= 1'b0;
      nack_q   <= 1'b0;
      aseq_q   <= '0;
    end else begin
      rx_q     <= rx_d;
      cls_q    <= cls_d;
      seq_q    <= seq_d;
      last_q   <= last_d;
      idx_q    <= idx_d;
      addr_q   <= addr_d;
      expect_q <= expect_d;
      total_q  <= total_d;
      cmpl_q   <= cmpl_d;
      ackv_q   <= ackv_d;
      nack_q   <= nack_d;
      aseq_q   <= aseq_d;
    end
  end

  assign mem_we       = (rx_q == RX_PAY) && cell_valid && (cls_q == CELL_ACC);
  assign mem_waddr    = addr_q;
  assign mem_wdata    = cell_data;
  assign ack_valid    = ackv_q;
  assign ack_nack     = nack_q;
  assign ack_seq      = aseq_q;
  assign img_complete = cmpl_q;
  assign img_words    = (AW+1)'(total_q) * (AW+1)'(WPC);

  // R1/R2: writes land only inside the window of the expected cell
  p_write_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_waddr) >= int'(expect_q) * WPC) &&
               (int'(mem_waddr) <  (int'(expect_q) + 1) * WPC));
  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);
  p_complete_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    img_complete |=> img_complete);
  p_no_write_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    img_complete |-> !mem_we);
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_ldr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AW       = 10,
  parameter int INIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              img_complete,
  input  logic [AW:0]       img_words,
  input  logic              cmd_valid,
  input  logic              cmd_partial,
  output logic              cmd_resp_valid,
  output logic              cmd_resp_ok,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_prog_n,
  input  logic              dev_ready,
  output logic              cfg_we,
  output logic [7:0]        cfg_byte,
  input  logic              cfg_busy,
  output logic              prog_done
);
  localparam int BPW  = DATA_W / 8;
  localparam int BI_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int IW   = $clog2(INIT_CYC + 1);
  localparam int SW   = AW + 1 + BI_W + 1;
  localparam logic [BI_W-1:0] BYTE_END = BI_W'(BPW - 1);
  localparam logic [IW-1:0]   INIT_END = IW'(INIT_CYC - 1);

  strm_st_e          st_q, st_d;
  logic              part_q, part_d;
  logic [AW-1:0]     word_q, word_d;
  logic [BI_W-1:0]   byte_q, byte_d;
  logic [IW-1:0]     init_q, init_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              rv_q, rv_d, rok_q, rok_d;
  logic [SW-1:0]     sent_q, sent_d;
  logic              can_start, we_now;

  assign can_start = img_complete && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign we_now    = (st_q == ST_SEND) && !cfg_busy;

  always_comb begin
    st_d    = st_q;
    part_d  = part_q;
    word_d  = word_q;
    byte_d  = byte_q;
    init_d  = init_q;
    shift_d = shift_q;
    sent_d  = we_now ? sent_q + 1'b1 : sent_q;
    rv_d    = cmd_valid;
    rok_d   = cmd_valid && can_start;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (cmd_valid && can_start) begin
          part_d = cmd_partial;
          word_d = '0;
          byte_d = '0;
          init_d = '0;
          sent_d = '0;
          st_d   = cmd_partial ? ST_FETCH : ST_INIT;
        end
      end
      ST_INIT: begin
        if (init_q == INIT_END) st_d = ST_WAIT;
        else                    init_d = init_q + 1'b1;
      end
      ST_WAIT:  if (dev_ready) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_LATCH;
      ST_LATCH: begin
        shift_d = mem_rdata;
        st_d    = ST_SEND;
      end
      default: begin
        if (!cfg_busy) begin
          shift_d = shift_q << 8;
          if (byte_q == BYTE_END) begin
            byte_d = '0;
            if ({1'b0, word_q} == img_words - 1'b1) begin
              st_d = ST_DONE;
            end else begin
              word_d = word_q + 1'b1;
              st_d   = ST_FETCH;
            end
          end else begin
            byte_d = byte_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      part_q  <= 1'b0;
      word_q  <= '0;
      byte_q  <= '0;
      init_q  <= '0;
      shift_q <= '0;
      rv_q    <= 1'b0;
      rok_q   <= 1'b0;
      sent_q  <= '0;
    end else begin
      st_q    <= st_d;
      part_q  <= part_d;
      word_q  <= word_d;
      byte_q  <= byte_d;
      init_q  <= init_d;
      shift_q <= shift_d;
      rv_q    <= rv_d;
      rok_q   <= rok_d;
      sent_q  <= sent_d;
    end
  end

  assign cmd_resp_valid = rv_q;
  assign cmd_resp_ok    = rok_q;
  assign mem_re         = (st_q == ST_FETCH);
  assign mem_raddr      = word_q;
  assign dev_prog_n     = (st_q != ST_INIT);
  assign cfg_we         = we_now;
  assign cfg_byte       = shift_q[DATA_W-1 -: 8];
  assign prog_done      = (st_q == ST_DONE);

  p_ok_needs_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_resp_valid && cmd_resp_ok) |-> img_complete);
  p_partial_no_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_prog_n) |-> !part_q);
  p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SEND) && cfg_busy) |=> $stable(cfg_byte));
  p_done_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_done) |-> (sent_q == SW'(img_words) * SW'(BPW)));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int DATA_W   = 32,
  parameter int WPC      = 11,
  parameter int SEQ_W    = 6,
  parameter int INIT_CYC = 4,
  localparam int AW      = $clog2((2 ** SEQ_W) * WPC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  input  logic              cell_sop,
  input  logic [DATA_W-1:0] cell_data,
  output logic              ack_valid,
  output logic              ack_nack,
  output logic [SEQ_W-1:0]  ack_seq,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_partial,
  output logic              cmd_resp_valid,
  output logic              cmd_resp_ok,
  output logic              img_complete,
  output logic              dev_prog_n,
  input  logic              dev_ready,
  output logic              cfg_we,
  output logic [7:0]        cfg_byte,
  input  logic              cfg_busy,
  output logic              prog_done
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_s;
  logic [AW:0] img_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cfg_cell_rx #(.DATA_W(DATA_W), .WPC(WPC), .SEQ_W(SEQ_W), .AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n_s),
    .cell_valid(cell_valid), .cell_sop(cell_sop), .cell_data(cell_data),
    .ack_valid(ack_valid), .ack_nack(ack_nack), .ack_seq(ack_seq),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .img_complete(img_complete), .img_words(img_words)
  );

  cfg_streamer #(.DATA_W(DATA_W), .AW(AW), .INIT_CYC(INIT_CYC)) u_strm (
    .clk(clk), .rst_n(rst_n_s),
    .img_complete(img_complete), .img_words(img_words),
    .cmd_valid(cmd_valid), .cmd_partial(cmd_partial),
    .cmd_resp_valid(cmd_resp_valid), .cmd_resp_ok(cmd_resp_ok),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .dev_prog_n(dev_prog_n), .dev_ready(dev_ready),
    .cfg_we(cfg_we), .cfg_byte(cfg_byte), .cfg_busy(cfg_busy),
    .prog_done(prog_done)
  );
endmodule

// File: tb/cfg_image_loader_bench.sv
module cfg_image_loader_bench;
  localparam int WPC   = 11;
  localparam int NCELL = 3;
  localparam int NWORD = NCELL * WPC;
  localparam int NBYTE = NWORD * 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cell_valid, cell_sop, cmd_valid, cmd_partial, dev_ready, cfg_busy;
  logic [31:0] cell_data, mem_rdata, mem_wdata;
  logic ack_valid, ack_nack, mem_we, mem_re, cmd_resp_valid, cmd_resp_ok;
  logic img_complete, dev_prog_n, cfg_we, prog_done;
  logic [5:0] ack_seq;
  logic [9:0] mem_waddr, mem_raddr;
  logic [7:0] cfg_byte;

  cfg_image_loader u_cfg_image_loader (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_sop(cell_sop),
    .cell_data(cell_data), .ack_valid(ack_valid), .ack_nack(ack_nack),
    .ack_seq(ack_seq), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_partial(cmd_partial),
    .cmd_resp_valid(cmd_resp_valid), .cmd_resp_ok(cmd_resp_ok),
    .img_complete(img_complete), .dev_prog_n(dev_prog_n), .dev_ready(dev_ready),
    .cfg_we(cfg_we), .cfg_byte(cfg_byte), .cfg_busy(cfg_busy),
    .prog_done(prog_done)
  );

  // program memory model, one-cycle read latency
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_raddr];
  end

  // configuration port monitor
  logic [7:0] cap [0:255];
  int ncap, lowcnt, bad_busy, we_noready;
  logic mon_clr = 1'b0;
  always @(negedge clk) begin
    if (mon_clr) begin
      ncap = 0; lowcnt = 0; bad_busy = 0; we_noready = 0;
    end else begin
      if (!dev_prog_n) lowcnt++;
      if (cfg_we) begin
        if (ncap < 256) cap[ncap] = cfg_byte;
        ncap++;
        if (cfg_busy) bad_busy++;
        if (!dev_ready) we_noready++;
      end
    end
  end

  int tests = 0, fails = 0;

  function automatic logic [31:0] imgw(int a);
    return {8'(a), 8'(a ^ 8'h5A), 8'(a + 8'h33), 8'(a * 3 + 1)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(negedge clk); #1 mon_clr = 1'b0;
  endtask

  // sends one cell and checks its acknowledgement (R1, R4, R12)
  task automatic send_cell(int seq, bit last, bit flip, bit gaps, bit exp_nack, int exp_seq, string req);
    int early = 0;
    cell_valid = 1'b1; cell_sop = 1'b1;
    cell_data = {last, 25'd0, 6'(seq)};
    @(posedge clk); #1;
    cell_sop = 1'b0;
    for (int k = 0; k < WPC; k++) begin
      if (gaps && (k % 3 == 1)) begin
        cell_valid = 1'b0; cell_data = 32'h0BAD0BAD;
        @(posedge clk); #1;
      end
      cell_valid = 1'b1;
      cell_data = imgw(seq * WPC + k) ^ (flip ? 32'hFFFF_FFFF : 32'h0);
      if (k != WPC - 1) begin
        @(negedge clk); if (ack_valid) early++;
      end
      @(posedge clk); #1;
    end
    cell_valid = 1'b0;
    @(negedge clk);
    chk(early == 0, "R4", "ack before last beat", early, 0);
    chk(ack_valid === 1'b1, "R4", "ack_valid after last beat", ack_valid, 1);
    chk(ack_nack === exp_nack, req, "ack_nack", ack_nack, exp_nack);
    chk(ack_seq === 6'(exp_seq), req, "ack_seq", ack_seq, exp_seq);
    @(negedge clk);
    chk(ack_valid === 1'b0, "R4", "ack one cycle wide", ack_valid, 0);
  endtask

  task automatic send_cmd(bit partial, bit exp_ok, string req);
    cmd_valid = 1'b1; cmd_partial = partial;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    chk(cmd_resp_valid === 1'b1 && cmd_resp_ok === exp_ok, req, "command response",
        {cmd_resp_valid, cmd_resp_ok}, {1'b1, exp_ok});
  endtask

  function automatic int byte_errs();
    int e = 0;
    for (int i = 0; i < NBYTE && i < 256; i++) begin
      logic [31:0] w;
      w = imgw(i / 4);
      if (cap[i] !== w[31 - 8*(i%4) -: 8]) e++;
    end
    return e;
  endfunction

  task automatic t_reset();
    chk(ack_valid === 1'b0 && img_complete === 1'b0 && prog_done === 1'b0, "R5",
        "reset outputs", {ack_valid, img_complete, prog_done}, 0);
    chk(dev_prog_n === 1'b1 && cfg_we === 1'b0 && mem_we === 1'b0, "R7",
        "reset port idle", {dev_prog_n, cfg_we, mem_we}, 3'b100);
  endtask

  task automatic t_early_start();
    clear_mon();
    send_cmd(1'b0, 1'b0, "R6");
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(ncap == 0 && lowcnt == 0, "R6", "no activity after rejected start", ncap + lowcnt, 0);
  endtask

  task automatic t_first_cell();
    int e = 0;
    @(posedge clk); #1;
    send_cell(0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R1");
    for (int k = 0; k < WPC; k++) if (mem[k] !== imgw(k)) e++;
    chk(e == 0, "R12", "cell 0 stored despite idle beats", e, 0);
  endtask

  task automatic t_out_of_order();
    int e = 0;
    send_cell(2, 1'b1, 1'b0, 1'b0, 1'b1, 1, "R2");
    for (int k = 2*WPC; k < 3*WPC; k++) if (mem[k] !== 32'hDEADBEEF) e++;
    chk(e == 0, "R2", "skipped cell not written", e, 0);
    chk(img_complete === 1'b0, "R5", "complete after rejected final", img_complete, 0);
  endtask

  task automatic t_duplicate();
    int e = 0;
    send_cell(0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R3");
    for (int k = 0; k < WPC; k++) if (mem[k] !== imgw(k)) e++;
    chk(e == 0, "R3", "duplicate not rewritten", e, 0);
  endtask

  task automatic t_complete();
    send_cell(1, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R1");
    chk(img_complete === 1'b0, "R5", "complete before final cell", img_complete, 0);
    send_cell(2, 1'b1, 1'b0, 1'b0, 1'b0, 2, "R5");
    chk(img_complete === 1'b1, "R5", "complete after final cell", img_complete, 1);
    chk(mem[NWORD-1] === imgw(NWORD-1), "R1", "last word address", mem[NWORD-1], imgw(NWORD-1));
  endtask

  task automatic t_full_program();
    bit fin = 0;
    clear_mon();
    dev_ready = 1'b0;
    send_cmd(1'b0, 1'b1, "R6");
    fork
      begin
        bit seen_low = 0; int after = 0;
        for (int k = 0; k < 5000 && !fin; k++) begin
          @(posedge clk); #1;
          cfg_busy = (k % 3 == 1);
          if (!dev_prog_n) seen_low = 1;
          if (seen_low && dev_prog_n) after++;
          dev_ready = (after >= 6);
          @(negedge clk);
          if (prog_done) fin = 1;
        end
      end
      begin
        repeat (20) @(posedge clk);
        #1 send_cell(1, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R11");
      end
    join
    cfg_busy = 1'b0;
    chk(fin == 1, "R10", "done raised", fin, 1);
    chk(lowcnt == 4, "R7", "init pulse length", lowcnt, 4);
    chk(we_noready == 0, "R7", "writes before ready", we_noready, 0);
    chk(bad_busy == 0, "R9", "writes while busy", bad_busy, 0);
    chk(ncap == NBYTE, "R10", "strobe count", ncap, NBYTE);
    chk(byte_errs() == 0, "R9", "byte order", byte_errs(), 0);
    @(negedge clk);
    chk(prog_done === 1'b1, "R10", "done holds", prog_done, 1);
  endtask

  task automatic t_partial_program();
    bit fin = 0;
    clear_mon();
    dev_ready = 1'b0;
    @(posedge clk); #1;
    send_cmd(1'b1, 1'b1, "R8");
    chk(prog_done === 1'b0, "R10", "done cleared by start", prog_done, 0);
    for (int k = 0; k < 5000 && !fin; k++) begin
      @(posedge clk); #1;
      cfg_busy = (k % 4 == 2);
      cmd_valid = (k == 5); cmd_partial = 1'b0;
      @(negedge clk);
      if (k == 6) chk(cmd_resp_valid === 1'b1 && cmd_resp_ok === 1'b0, "R6",
                      "start while streaming", {cmd_resp_valid, cmd_resp_ok}, 2'b10);
      if (prog_done) fin = 1;
    end
    cfg_busy = 1'b0;
    chk(fin == 1, "R10", "partial done", fin, 1);
    chk(lowcnt == 0, "R8", "no init pulse", lowcnt, 0);
    chk(we_noready == NBYTE, "R8", "writes without ready", we_noready, NBYTE);
    chk(ncap == NBYTE && byte_errs() == 0, "R9", "partial bytes", byte_errs(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
    rst_n = 1'b0; cell_valid = 1'b0; cell_sop = 1'b0; cell_data = '0;
    cmd_valid = 1'b0; cmd_partial = 1'b0; dev_ready = 1'b0; cfg_busy = 1'b0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        @(posedge clk); #1;
        t_early_start();
        t_first_cell();
        t_out_of_order();
        t_duplicate();
        t_complete();
        t_full_program();
        t_partial_program();
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule